// File: doc/BRIEF.md
# Two-Cycle Signed/Unsigned Fractional Multiplier

This unit multiplies two 8-bit operands in one of six modes. The modes come from three signedness pairings (both unsigned, both two's-complement, and two's-complement first operand times unsigned second operand). Each pairing has an integer form and a fixed-point fractional form. The fractional form moves the product left by one bit, so that a product of two 1.7 fractions lands as a 1.15 fraction.

The 16-bit result is delivered as a high byte and a low byte for a fixed destination register pair. A carry flag and a zero flag come with it, and no other flag is produced.

A caller raises `start` for one cycle with the operands and the mode. On the second rising edge after that, the result and the flags are valid and `done` pulses. The unit holds one operation at a time. A `start` that arrives while an operation is in flight is dropped. A `start` in the cycle that `done` is high begins the next operation, so results can follow one another every two cycles.

Top module: `fmul_unit`

## Requirements
- R1: `mode[1:0]` selects the operand interpretation: 0 treats both operands as unsigned; 1 treats both as two's-complement; 2 treats `op_a` as two's-complement and `op_b` as unsigned; 3 behaves as 0. `mode[2]`=1 selects the fractional form of that pairing.
- R2: In integer form, {`prod_hi`,`prod_lo`} equals the low 16 bits of the two's-complement product of the interpreted operands. `prod_hi` carries bits 15..8 and `prod_lo` carries bits 7..0.
- R3: In fractional form, the result is the integer-form product shifted left by one bit, so bit 0 of `prod_lo` is 0.
- R4: `c_flag` equals bit 15 of the product before any fractional shift.
- R5: `z_flag` is 1 exactly when the delivered 16-bit result (after any shift) is zero.
- R6: A `start` seen at a rising edge while the unit is idle captures `op_a`, `op_b` and `mode` at that edge. The result, the flags and `done`=1 appear after the following rising edge.
- R7: `done` is high for exactly one cycle per accepted operation.
- R8: A `start` seen at the rising edge that ends the busy cycle is ignored. It neither changes the pending result nor produces an extra `done`.
- R9: A `start` presented in the cycle in which `done` is high is accepted, and its result arrives two edges later.
- R10: `prod_hi`, `prod_lo`, `z_flag` and `c_flag` hold their values until the next `done`.
- R11: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a multiply |
| mode | input | 3 | Bit 2: fractional form; bits 1..0: signedness pairing |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| prod_hi | output | 8 | Result bits 15..8 |
| prod_lo | output | 8 | Result bits 7..0 |
| z_flag | output | 1 | Zero flag of the result |
| c_flag | output | 1 | Carry flag: bit 15 of the unshifted product |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The two events that can share a cycle are the delivery of one result (`done` high) and the acceptance of the next `start`. The bench provokes this by raising `start` with new operands in the `done` cycle. It then confirms three things: the first result is still on the outputs in that cycle, `done` falls in the next cycle while the old values hold, and the second result appears one edge later. The neighbouring case is also provoked: `start` raised during the busy cycle must leave the pending result unchanged and produce no second `done`.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
   // signedness pairing held in the two low mode bits
   typedef enum logic [1:0] {
      SG_UU  = 2'd0,
      SG_SS  = 2'd1,
      SG_SU  = 2'd2,
      SG_RSV = 2'd3
   } sign_pair_e;

   localparam int MODE_W   = 3;
   localparam int FRAC_BIT = 2;
endpackage

// File: rtl/fmul_opnd_ext.sv
// Widens an operand by one bit, filling with its sign only when it is to be read as signed.
module fmul_opnd_ext #(
   parameter int W = 8
) (
   input  logic [W-1:0] val,
   input  logic         is_signed,
   output logic [W:0]   ext
);
   assign ext = {is_signed & val[W-1], val};
endmodule

// File: rtl/fmul_array.sv
// Product of two (W+1)-bit two's-complement numbers, kept modulo 2^(2W).
module fmul_array #(
   parameter int W         = 8,
   parameter int MULT_IMPL = 0   // 0: inferred operator, 1: explicit shift-add
) (
   input  logic [W:0]     a_ext,
   input  logic [W:0]     b_ext,
   output logic [2*W-1:0] raw
);
   localparam int PW = 2 * W;

   logic [PW-1:0] aw;
   assign aw = {{(W-1){a_ext[W]}}, a_ext};

   generate
      if (MULT_IMPL == 0) begin : g_operator
         logic [PW-1:0] bw;
         assign bw  = {{(W-1){b_ext[W]}}, b_ext};
         assign raw = aw * bw;
      end else begin : g_shift_add
         logic [PW-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < W; i++) begin
               if (b_ext[i]) acc = acc + (aw << i);
            end
            // sign bit of the widened multiplier carries negative weight
            if (b_ext[W]) acc = acc - (aw << W);
         end
         assign raw = acc;
      end
   endgenerate
endmodule

// File: rtl/fmul_result.sv
// Applies the optional fractional shift and derives the two flags.
module fmul_result #(
   parameter int W = 8
) (
   input  logic [2*W-1:0] raw,
   input  logic           frac,
   output logic [2*W-1:0] res,
   output logic           zero,
   output logic           carry
);
   localparam int PW = 2 * W;

   assign res   = frac ? {raw[PW-2:0], 1'b0} : raw;
   assign carry = raw[PW-1];
   assign zero  = (res == '0);
endmodule

// File: rtl/fmul_unit.sv
module fmul_unit #(
   parameter int W         = 8,
   parameter int MULT_IMPL = 0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [fmul_pkg::MODE_W-1:0] mode,
   input  logic [W-1:0]               op_a,
   input  logic [W-1:0]               op_b,
   output logic [W-1:0]               prod_hi,
   output logic [W-1:0]               prod_lo,
   output logic                       z_flag,
   output logic                       c_flag,
   output logic                       done
);
   import fmul_pkg::*;

   localparam int PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_width
         $error("fmul_unit: W must be at least 2");
      end
      if (MULT_IMPL != 0 && MULT_IMPL != 1) begin : g_bad_impl
         $error("fmul_unit: MULT_IMPL must be 0 or 1");
      end
   endgenerate

   logic                busy_q;
   logic                done_q;
   logic [W-1:0]        a_q, b_q;
   logic [MODE_W-1:0]   mode_q;
   logic [PW-1:0]       prod_q;
   logic                z_q, c_q;

   sign_pair_e          pair;
   logic                a_signed, b_signed;
   logic [W:0]          a_ext, b_ext;
   logic [PW-1:0]       raw_w, res_w;
   logic                z_w, c_w;

   assign pair     = sign_pair_e'(mode_q[1:0]);
   assign a_signed = (pair == SG_SS) || (pair == SG_SU);
   assign b_signed = (pair == SG_SS);

   fmul_opnd_ext #(.W(W)) ext_a_i (.val(a_q), .is_signed(a_signed), .ext(a_ext));
   fmul_opnd_ext #(.W(W)) ext_b_i (.val(b_q), .is_signed(b_signed), .ext(b_ext));

   fmul_array #(.W(W), .MULT_IMPL(MULT_IMPL)) array_i (
      .a_ext (a_ext),
      .b_ext (b_ext),
      .raw   (raw_w)
   );

   fmul_result #(.W(W)) result_i (
      .raw   (raw_w),
      .frac  (mode_q[FRAC_BIT]),
      .res   (res_w),
      .zero  (z_w),
      .carry (c_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         a_q    <= '0;
         b_q    <= '0;
         mode_q <= '0;
         prod_q <= '0;
         z_q    <= 1'b0;
         c_q    <= 1'b0;
      end else begin
         done_q <= busy_q;
         if (start && !busy_q) begin
            busy_q <= 1'b1;
            a_q    <= op_a;
            b_q    <= op_b;
            mode_q <= mode;
         end else begin
            busy_q <= 1'b0;
         end
         if (busy_q) begin
            prod_q <= res_w;
            z_q    <= z_w;
            c_q    <= c_w;
         end
      end
   end

   assign prod_hi = prod_q[PW-1:W];
   assign prod_lo = prod_q[W-1:0];
   assign z_flag  = z_q;
   assign c_flag  = c_q;
   assign done    = done_q;
endmodule

// File: rtl/fmul_unit_chk.sv
module fmul_unit_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         frac,
   input logic         done,
   input logic [W-1:0] prod_hi,
   input logic [W-1:0] prod_lo,
   input logic         z_flag,
   input logic         c_flag
);
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> done); // R6
   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> !busy); // R8
   AST_START_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> busy); // R9
   AST_FRAC_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frac) |=> (prod_lo[0] == 1'b0)); // R3
   AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z_flag == ({prod_hi, prod_lo} == '0))); // R5
   AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(prod_hi) && $stable(prod_lo) && $stable(z_flag) && $stable(c_flag))); // R10
endmodule

bind fmul_unit fmul_unit_chk #(.W(W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy_q),
   .frac    (mode_q[fmul_pkg::FRAC_BIT]),
   .done    (done),
   .prod_hi (prod_hi),
   .prod_lo (prod_lo),
   .z_flag  (z_flag),
   .c_flag  (c_flag)
);

// File: tb/fmul_unit_tb_top.sv
module fmul_unit_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] mode = 3'd0;
   logic [7:0] op_a = 8'd0;
   logic [7:0] op_b = 8'd0;
   logic [7:0] prod_hi, prod_lo;
   logic       z_flag, c_flag, done;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fmul_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .op_a(op_a), .op_b(op_b), .prod_hi(prod_hi), .prod_lo(prod_lo),
      .z_flag(z_flag), .c_flag(c_flag), .done(done)
   );

   // fields: [36:34] mode, [33:26] a, [25:18] b, [17:2] result, [1] z, [0] c
   localparam logic [36:0] VECS [13] = '{
      {3'b000, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},
      {3'b001, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},
      {3'b101, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
      {3'b010, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},
      {3'b110, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b1},
      {3'b100, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},
      {3'b100, 8'h80, 8'h00, 16'h0000, 1'b1, 1'b0},
      {3'b100, 8'hFF, 8'hFF, 16'hFC02, 1'b0, 1'b1},
      {3'b001, 8'hFF, 8'h01, 16'hFFFF, 1'b0, 1'b1},
      {3'b101, 8'h40, 8'h40, 16'h2000, 1'b0, 1'b0},
      {3'b001, 8'h7F, 8'h81, 16'hC0FF, 1'b0, 1'b1},
      {3'b010, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},
      {3'b011, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1}
   };

   function automatic logic [17:0] ref_mul(logic [2:0] m, logic [7:0] a, logic [7:0] b);
      int av, bv, p;
      logic [15:0] rawp, resp;
      av = int'(a);
      bv = int'(b);
      if ((m[1:0] == 2'd1 || m[1:0] == 2'd2) && a[7]) av = av - 256;
      if (m[1:0] == 2'd1 && b[7]) bv = bv - 256;
      p = av * bv;
      rawp = p[15:0];
      resp = m[2] ? (rawp << 1) : rawp;
      return {resp, (resp == 16'h0000), rawp[15]};
   endfunction

   task automatic check(string req, logic [15:0] er, logic ez, logic ec, logic ed);
      checks++;
      if ({prod_hi, prod_lo} !== er || z_flag !== ez || c_flag !== ec || done !== ed) begin
         errors++;
         $display("FAIL %s: got res=%h z=%b c=%b done=%b expected res=%h z=%b c=%b done=%b",
                  req, {prod_hi, prod_lo}, z_flag, c_flag, done, er, ez, ec, ed);
      end
   endtask

   // one operation: drive, drop start after the accepting edge, check after the second edge
   task automatic run_op(logic [2:0] m, logic [7:0] a, logic [7:0] b);
      @(negedge clk);
      start = 1'b1; mode = m; op_a = a; op_b = b;
      @(negedge clk);
      start = 1'b0; op_a = ~a; op_b = ~b; mode = ~m;
      @(negedge clk);
   endtask

   initial begin
      logic [17:0] e;
      logic [15:0] held;
      logic [2:0] modes [6] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd6};

      repeat (3) @(negedge clk);
      check("R11 reset", 16'h0000, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after release", 16'h0000, 1'b0, 1'b0, 1'b0);

      // R1 R2 R3 R4 R5 R6: table of corner vectors
      foreach (VECS[i]) begin
         run_op(VECS[i][36:34], VECS[i][33:26], VECS[i][25:18]);
         check("R1/R2/R3/R4/R5/R6 vector", VECS[i][17:2], VECS[i][1], VECS[i][0], 1'b1);
         @(negedge clk);
         check("R7/R10 hold after done", VECS[i][17:2], VECS[i][1], VECS[i][0], 1'b0);
      end

      // sweep: every first operand against a spread of second operands in all six modes
      for (int mi = 0; mi < 6; mi++) begin
         for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 19; bi++) begin
               logic [7:0] bval;
               bval = (bi < 16) ? 8'(bi * 17) : (bi == 16 ? 8'h80 : (bi == 17 ? 8'h7F : 8'h01));
               e = ref_mul(modes[mi], 8'(ai), bval);
               run_op(modes[mi], 8'(ai), bval);
               check("R2/R3/R4/R5 sweep", e[17:2], e[1], e[0], 1'b1);
            end
         end
      end

      // R8: start raised during busy cycle is dropped
      @(negedge clk);
      start = 1'b1; mode = 3'd0; op_a = 8'd3; op_b = 8'd5;
      @(negedge clk);
      start = 1'b1; mode = 3'd1; op_a = 8'hFF; op_b = 8'h02;
      @(negedge clk);
      start = 1'b0;
      check("R8 busy start ignored, first result", 16'h000F, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      check("R8 no extra done", 16'h000F, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R8 still idle", 16'h000F, 1'b0, 1'b0, 1'b0);

      // R9: start in the done cycle
      @(negedge clk);
      start = 1'b1; mode = 3'd0; op_a = 8'd16; op_b = 8'd16;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check("R9 first result", 16'h0100, 1'b0, 1'b0, 1'b1);
      start = 1'b1; mode = 3'd5; op_a = 8'hC0; op_b = 8'h40;   // -64*64=-4096 -> F000, shifted E000
      @(negedge clk);
      start = 1'b0;
      check("R9 gap cycle holds", 16'h0100, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check("R9 second result", 16'hE000, 1'b0, 1'b1, 1'b1);

      // R5: zero from a zero operand in a signed mode
      run_op(3'd6, 8'h00, 8'hFF);
      check("R5 zero signed-unsigned", 16'h0000, 1'b1, 1'b0, 1'b1);

      // R11: reset clears a held result
      held = {prod_hi, prod_lo};
      run_op(3'd0, 8'hFF, 8'hFF);
      rst_n = 1'b0;
      #1;
      check("R11 reset clears result", 16'h0000, 1'b0, 1'b0, 1'b0);
      if (held == 16'hFFFF) $display("note: unreachable");

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule